// File: doc/BRIEF.md
# Gigabit Receive Carrier Extension Error Counter

This block sits beside a byte-wide GMII receiver and counts the received frames in which the PHY reported an error while extending carrier. It watches `rx_dv`, `rx_er` and `rxd` every cycle and follows each reception through three phases: idle, frame data, and carrier extension. Carrier extension is the stretch right after the data in which `rx_dv` is low, `rx_er` is high and `rxd` carries the extension symbol 0x0F. When the error symbol 0x1F appears in that stretch, the frame is flagged. A frame is flagged at most once, and each flagged frame adds one to a statistics counter.

Counting is allowed only while receive is enabled and the link runs at gigabit speed. The counter is `CNT_W` bits wide, 32 by default. It stops at its all-ones value instead of wrapping. Software-facing logic reads it with a one-cycle request. The request latches the current value onto the read data output and clears the counter in the same step.

Top module: `rx_ext_err_counter`

## Requirements
- R1: After reset the counter and `rd_data` are both zero.
- R2: A cycle with `rx_dv`=0, `rx_er`=1 and `rxd`=0x1F counts one frame when it comes directly after a data cycle (`rx_dv`=1) or after an extension cycle. An extension cycle has `rx_dv`=0, `rx_er`=1 and `rxd` equal to 0x0F or 0x1F.
- R3: The 0x1F code is ignored in every other case: during idle with no frame before it, after the extension has ended, during data (`rx_dv`=1), and when `rx_er`=0.
- R4: Several error codes in one extension period add only one to the count. A frame that begins when `rx_dv` rises again is counted separately.
- R5: An error code counts only if `rx_en`=1 and `link_gig`=1 in the same cycle as the code.
- R6: If `rd_req` is high at a clock edge, `rd_data` shows the counter value from before that edge, starting one cycle later and held until the next request. The counter is cleared to zero.
- R7: If a read and an increment fall on the same edge, the read returns the old value and the counter becomes one.
- R8: The counter saturates at all ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error / carrier extension indicator |
| rxd | input | 8 | Receive data byte |
| rx_en | input | 1 | Receive enabled |
| link_gig | input | 1 | Link operates at 1000 Mb/s |
| rd_req | input | 1 | Read-and-clear request, one cycle |
| rd_data | output | CNT_W | Counter value captured by the last read |

## Verification
The bench targets the three places where the error code looks valid but is not:

- **Idle before any frame.** A design that skipped phase tracking would count here.
- **During data.** A design that ignored `rx_dv` would count here.
- **After an extension that has already returned to idle.** A design that never left the extension phase would count here.

It repeats the error code inside one extension, which a design without a per-frame flag would count several times. It then starts a second frame straight out of extension, which a design that failed to re-arm would miss.

A read and an increment are placed on the same edge. A design that gave priority to the clear would lose that event. A narrow second instance is driven past its maximum, where a wrapping counter would fall back to a small value.

// File: rtl/rx_ext_pkg.sv
package rx_ext_pkg;

    localparam int unsigned GMII_W = 8;

    // Symbols carried on rxd while rx_dv is low and rx_er is high
    localparam logic [GMII_W-1:0] SYM_EXTEND   = 8'h0F;
    localparam logic [GMII_W-1:0] SYM_EXT_FAIL = 8'h1F;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_EXT  = 2'd2
    } phase_e;

endpackage

// File: rtl/rx_ext_phase.sv
module rx_ext_phase
    import rx_ext_pkg::*;
#(
    parameter int unsigned DATA_W = GMII_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [DATA_W-1:0] rxd,
    output phase_e            phase_q,
    output logic              frame_start,
    output logic              ext_fail
);

    typedef struct packed {
        phase_e ph;
    } st_t;

    st_t st_d, st_q;

    logic is_ext_sym;
    logic is_fail_sym;
    logic after_data;

    always_comb begin
        is_fail_sym = !rx_dv && rx_er && (rxd == DATA_W'(SYM_EXT_FAIL));
        is_ext_sym  = (!rx_dv && rx_er && (rxd == DATA_W'(SYM_EXTEND))) || is_fail_sym;
        after_data  = (st_q.ph == PH_DATA) || (st_q.ph == PH_EXT);

        frame_start = rx_dv && (st_q.ph != PH_DATA);
        ext_fail    = after_data && is_fail_sym;

        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (rx_dv) st_d.ph = PH_DATA;
            end
            PH_DATA, PH_EXT: begin
                if (rx_dv)           st_d.ph = PH_DATA;
                else if (is_ext_sym) st_d.ph = PH_EXT;
                else                 st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE};
        else        st_q <= st_d;
    end

    assign phase_q = st_q.ph;

endmodule

// File: rtl/rx_ext_flag.sv
module rx_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic ext_fail,
    input  logic gate,
    output logic inc_q
);

    typedef struct packed {
        logic armed;
        logic inc;
    } st_t;

    st_t st_d, st_q;
    logic take;

    always_comb begin
        take = ext_fail && gate && st_q.armed;
        st_d = st_q;
        st_d.inc = take;
        if (frame_start) st_d.armed = 1'b1;
        else if (take)   st_d.armed = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{armed: 1'b0, inc: 1'b0};
        else        st_q <= st_d;
    end

    assign inc_q = st_q.inc;

endmodule

// File: rtl/rx_ext_stat.sv
module rx_ext_stat #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             rd_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rdv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_req) begin
            st_d.rdv = st_q.cnt;
            st_d.cnt = inc ? CNT_W'(1) : '0;
        end else if (inc && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, rdv: '0};
        else        st_q <= st_d;
    end

    assign cnt_q   = st_q.cnt;
    assign rd_data = st_q.rdv;

endmodule

// File: rtl/rx_ext_err_counter.sv
module rx_ext_err_counter
    import rx_ext_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic             rx_er,
    input  logic [7:0]       rxd,
    input  logic             rx_en,
    input  logic             link_gig,
    input  logic             rd_req,
    output logic [CNT_W-1:0] rd_data
);

    phase_e           phase_w;
    logic             start_w;
    logic             fail_w;
    logic             inc_w;
    logic [CNT_W-1:0] cnt_w;
    logic             gate_w;

    assign gate_w = rx_en && link_gig;

    rx_ext_phase #(.DATA_W(GMII_W)) phase_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_dv       (rx_dv),
        .rx_er       (rx_er),
        .rxd         (rxd),
        .phase_q     (phase_w),
        .frame_start (start_w),
        .ext_fail    (fail_w)
    );

    rx_ext_flag flag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (start_w),
        .ext_fail    (fail_w),
        .gate        (gate_w),
        .inc_q       (inc_w)
    );

    rx_ext_stat #(.CNT_W(CNT_W)) stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_w),
        .rd_req  (rd_req),
        .cnt_q   (cnt_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/rx_ext_err_counter_chk.sv
module rx_ext_err_counter_chk
    import rx_ext_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             link_gig,
    input logic             rd_req,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] cnt_q,
    input logic             inc_q,
    input phase_e           ph_q
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    a_r2_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

    a_r3_not_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q |-> $past(ph_q) != PH_IDLE);

    a_r4_once_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q |=> !inc_q);

    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q |-> $past(rx_en && link_gig));

    a_r6_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_data == $past(cnt_q));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !inc_q) |=> cnt_q == '0);

    a_r7_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && inc_q) |=> cnt_q == CNT_W'(1));

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !rd_req) |=> cnt_q == MAXV);

endmodule

bind rx_ext_err_counter rx_ext_err_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .link_gig (link_gig),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .cnt_q    (cnt_w),
    .inc_q    (inc_w),
    .ph_q     (phase_w)
);

// File: tb/rx_ext_err_counter_tb_top.sv
module rx_ext_err_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_dv = 1'b0;
    logic        rx_er = 1'b0;
    logic [7:0]  rxd = 8'h00;
    logic        rx_en = 1'b1;
    logic        link_gig = 1'b1;
    logic        rd_req = 1'b0;
    logic        rd_req_s = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  rd_data_s;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_ext_err_counter #(.CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .rx_en(rx_en), .link_gig(link_gig), .rd_req(rd_req), .rd_data(rd_data)
    );

    rx_ext_err_counter #(.CNT_W(3)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .rx_en(rx_en), .link_gig(link_gig), .rd_req(rd_req_s), .rd_data(rd_data_s)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic dv, input logic er, input logic [7:0] d);
        @(negedge clk);
        rx_dv = dv; rx_er = er; rxd = d;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00);
    endtask

    task automatic data(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'(8'h40 + i));
    endtask

    task automatic read_main(output logic [31:0] v);
        @(negedge clk); rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk); rd_req = 1'b0;
        v = rd_data;
    endtask

    task automatic read_sat(output logic [2:0] v);
        @(negedge clk); rd_req_s = 1'b1;
        @(posedge clk);
        @(negedge clk); rd_req_s = 1'b0;
        v = rd_data_s;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rd_data after reset", rd_data, 0);
        read_main(v);
        check("R1 counter after reset", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        data(4);
        cyc(1'b0, 1'b1, 8'h0F); cyc(1'b0, 1'b1, 8'h0F);
        cyc(1'b0, 1'b1, 8'h1F); cyc(1'b0, 1'b1, 8'h0F);
        idle(3);
        read_main(v);
        check("R2 error mid extension", v, 1);
        data(3);
        cyc(1'b0, 1'b1, 8'h1F);
        idle(3);
        read_main(v);
        check("R2 error right after data", v, 1);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        data(5);
        cyc(1'b0, 1'b1, 8'h1F); cyc(1'b0, 1'b1, 8'h1F);
        cyc(1'b0, 1'b1, 8'h0F); cyc(1'b0, 1'b1, 8'h1F);
        idle(3);
        read_main(v);
        check("R4 several codes one frame", v, 1);
        data(2);
        cyc(1'b0, 1'b1, 8'h1F); cyc(1'b0, 1'b1, 8'h0F);
        data(2);
        cyc(1'b0, 1'b1, 8'h1F);
        idle(3);
        read_main(v);
        check("R4 burst frames rearm", v, 2);
    endtask

    task automatic t_outside();
        logic [31:0] v;
        cyc(1'b0, 1'b1, 8'h1F); cyc(1'b0, 1'b1, 8'h1F);
        idle(3);
        read_main(v);
        check("R3 code in idle", v, 0);
        data(2); cyc(1'b1, 1'b1, 8'h1F); data(1);
        cyc(1'b0, 1'b0, 8'h1F);
        idle(3);
        read_main(v);
        check("R3 code in data or without rx_er", v, 0);
        data(3); cyc(1'b0, 1'b1, 8'h0F); idle(1);
        cyc(1'b0, 1'b1, 8'h1F);
        idle(3);
        read_main(v);
        check("R3 code after extension ended", v, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        rx_en = 1'b0;
        data(3); cyc(1'b0, 1'b1, 8'h1F); idle(3);
        read_main(v);
        check("R5 receive disabled", v, 0);
        rx_en = 1'b1; link_gig = 1'b0;
        data(3); cyc(1'b0, 1'b1, 8'h1F); idle(3);
        read_main(v);
        check("R5 not gigabit", v, 0);
        link_gig = 1'b1;
    endtask

    task automatic t_read();
        logic [31:0] v;
        data(2); cyc(1'b0, 1'b1, 8'h1F); idle(2);
        data(2); cyc(1'b0, 1'b1, 8'h1F); idle(2);
        data(2); cyc(1'b0, 1'b1, 8'h1F); idle(3);
        read_main(v);
        check("R6 read returns count", v, 3);
        idle(2);
        check("R6 rd_data held", rd_data, 3);
        read_main(v);
        check("R6 read cleared counter", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        data(2); cyc(1'b0, 1'b1, 8'h1F); idle(3);
        data(2); cyc(1'b0, 1'b1, 8'h1F);
        // increment is registered one edge later; read lands on that edge
        @(negedge clk); rx_dv = 1'b0; rx_er = 1'b0; rxd = 8'h00; rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk); rd_req = 1'b0;
        check("R7 read returns old value", rd_data, 1);
        idle(2);
        read_main(v);
        check("R7 counter left at one", v, 1);
    endtask

    task automatic t_sat();
        logic [2:0] s;
        read_sat(s);
        for (int i = 0; i < 9; i++) begin
            data(2); cyc(1'b0, 1'b1, 8'h1F); idle(2);
        end
        read_sat(s);
        check("R8 saturated at max", s, 7);
        read_sat(s);
        check("R8 cleared after saturation", s, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_outside();
        t_gate();
        t_read();
        t_collide();
        t_sat();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule